// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing and Programmable Level Flags

This block is a first-in first-out buffer for 36-bit words. It has a write port and a read port, and each port runs on its own clock. The two clocks may be unrelated, or they may be the same clock. The write side is a valid/ready stream: a word is taken on a `wr_clk` edge when `wr_valid` and `wr_ready` are both high. `wr_ready` drops when the buffer holds `DEPTH` words. A producer must then hold its word until `wr_ready` returns.

The read side works in one of two timings, chosen at master reset:

- **Registered timing.** `rd_valid` means "not empty". A read is a `rd_ready` pulse while `rd_valid` is high. The word appears on `rd_data` just after that edge.
- **Fall-through timing.** The head word is placed on `rd_data` with no strobe, and `rd_valid` means that word is present. Asserting `rd_ready` consumes it, and the next word takes its place. A consumer that keeps `rd_ready` low stalls the stream, and `rd_data` is held.

Two level flags report near-empty and near-full conditions, each against its own offset. Each offset starts from one of three defaults chosen at master reset. Software-free logic can then overwrite the offsets, either as a parallel word or one bit per clock. There are two resets:

- **Master reset** clears the stored data and reloads the timing mode and the default offsets.
- **Partial reset** clears only the stored data.

Top module: `dual_mode_fifo`

## Requirements
- R1: Words leave in the order they were accepted, all 36 bits intact, for any `DEPTH` that is a power of two from 256 to 1024.
- R2: In registered timing (`mode_fwft`=0 at master reset), `rd_valid` is 1 exactly when the buffer holds a word. A read accepted on a `rd_clk` edge puts that word on `rd_data` after the edge. `rd_data` does not change on an edge without a read.
- R3: In fall-through timing (`mode_fwft`=1), the head word appears on `rd_data` with `rd_valid`=1 and no strobe. With `rd_ready`=1 on an edge the word is consumed. With `rd_ready`=0, `rd_valid` and `rd_data` are held.
- R4: `wr_ready` is 0 while `DEPTH` words are stored. A write offered while full is dropped and does not overwrite stored data.
- R5: A read requested while empty is ignored. `rd_data` is unchanged, and the next word written is the next word read.
- R6: `almost_empty` is 1 when the stored level (counting the word held on `rd_data` in fall-through timing) is less than or equal to the near-empty offset.
- R7: `almost_full` is 1 when the write-side level is at least `DEPTH` minus the near-full offset.
- R8: During master reset, `dflt_sel` sets both offsets: 00 gives 8, 01 gives 16, 10 or 11 gives 64.
- R9: `cfg_load`=1 on a `wr_clk` edge loads `cfg_ae` into the near-empty offset and `cfg_af` into the near-full offset. It takes priority over serial shifting.
- R10: With `ser_en`=1, each `wr_clk` edge shifts `ser_bit` into the low end of a 2×`AW`-bit register. The near-empty offset is the upper half and the near-full offset is the lower half. After 2×`AW` bits, the near-empty value (MSB first) is followed by the near-full value (MSB first).
- R11: `mrst_n`=0 (held for at least two edges of each clock) empties the buffer and samples `mode_fwft` and `dflt_sel`.
- R12: `prst_n`=0 empties the buffer but keeps the timing mode and any programmed offsets.
- R13: A read and a write on the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, synchronous to each clock |
| prst_n | input | 1 | Partial reset, active low, data only |
| mode_fwft | input | 1 | Timing select sampled in master reset (1 = fall-through) |
| dflt_sel | input | 2 | Default offset select sampled in master reset |
| cfg_load | input | 1 | Parallel offset load strobe (wr_clk) |
| cfg_ae | input | AW | Parallel near-empty offset |
| cfg_af | input | AW | Parallel near-full offset |
| ser_en | input | 1 | Serial offset shift enable (wr_clk) |
| ser_bit | input | 1 | Serial offset data bit |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Space available (not full) |
| wr_data | input | 36 | Write word |
| rd_valid | output | 1 | Not empty (registered) / word present (fall-through) |
| rd_ready | input | 1 | Read strobe / consume |
| rd_data | output | 36 | Read word |
| almost_empty | output | 1 | Near-empty flag, read domain |
| almost_full | output | 1 | Near-full flag, write domain |

## Verification
The bench fills the buffer to exactly `DEPTH` words and offers one more. A design with an off-by-one full test would either accept that word, corrupting the oldest entry, or refuse the last legal word. Reads are then issued against an empty buffer. A read pointer that advanced anyway would return a stale word in place of the next one written.

Each offset source is checked at the threshold and at one word past it: the three defaults, the parallel load, and the serial shift. A wrong bit order or a swapped half would move the threshold.

A partial reset is applied in fall-through timing after the offsets have been programmed. A design that reloaded the configuration would fall back to registered timing or to default offsets. A simultaneous read and write on one edge is also run; a design that let one side win would lose or repeat a word.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  localparam int WORD_W = 36;
  localparam int CONV_W = 16;

  typedef enum logic [1:0] {
    OFS_8   = 2'b00,
    OFS_16  = 2'b01,
    OFS_64  = 2'b10,
    OFS_64B = 2'b11
  } ofs_sel_e;

  function automatic logic [CONV_W-1:0] to_gray(input logic [CONV_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CONV_W-1:0] from_gray(input logic [CONV_W-1:0] g);
    logic [CONV_W-1:0] b;
    b[CONV_W-1] = g[CONV_W-1];
    for (int i = CONV_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [CONV_W-1:0] preset_offset(input ofs_sel_e s);
    case (s)
      OFS_8:   return 16'd8;
      OFS_16:  return 16'd16;
      default: return 16'd64;
    endcase
  endfunction
endpackage

// File: rtl/fifo_cfg.sv
module fifo_cfg
  import dmf_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          mode_in,
  input  logic [1:0]    dflt_sel,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_ae,
  input  logic [AW-1:0] cfg_af,
  input  logic          ser_en,
  input  logic          ser_bit,
  output logic          fwft,
  output logic [AW-1:0] ae_off,
  output logic [AW-1:0] af_off
);
  localparam int SW = 2 * AW;

  logic [SW-1:0] ofs_q;
  logic [AW-1:0] preset;

  assign preset = AW'(preset_offset(ofs_sel_e'(dflt_sel)));
  assign ae_off = ofs_q[SW-1:AW];
  assign af_off = ofs_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      fwft  <= mode_in;
      ofs_q <= {preset, preset};
    end else if (cfg_load) begin
      ofs_q <= {cfg_ae, cfg_af};
    end else if (ser_en) begin
      ofs_q <= {ofs_q[SW-2:0], ser_bit};
    end
  end

  // R9: a parallel load lands in both offsets on the next edge
  a_r9_parallel_load: assert property (@(posedge clk) disable iff (!mrst_n)
    cfg_load |=> (ae_off == $past(cfg_ae)) && (af_off == $past(cfg_af)));

  // R11/R12: timing mode only moves during master reset
  a_r11_mode_kept: assert property (@(posedge clk) disable iff (!mrst_n)
    mrst_n |=> $stable(fwft));
endmodule

// File: rtl/ptr_sync.sv
module ptr_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
  import dmf_pkg::*;
#(
  parameter int AW = 8,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          wr_valid,
  input  logic [PW-1:0] rgray_s,
  input  logic [AW-1:0] af_off,
  output logic          push,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          full,
  output logic          almost_full
);
  localparam logic [PW-1:0] CAP = PW'(1) << AW;

  logic [PW-1:0] wbin, wnext, rbin_s, wlevel;

  assign rbin_s      = PW'(from_gray(CONV_W'(rgray_s)));
  assign wlevel      = wbin - rbin_s;
  assign full        = (wlevel == CAP);
  assign almost_full = (wlevel >= (CAP - {1'b0, af_off}));
  assign push        = wr_valid && !full;
  assign wnext       = wbin + PW'(1);
  assign waddr       = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (clr) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wnext;
      wgray <= PW'(to_gray(CONV_W'(wnext)));
    end
  end

  // R4: an offer while full leaves the write pointer where it was
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (clr)
    (full && wr_valid) |=> $stable(wbin));

  // R1: the published pointer moves by at most one Gray step per edge
  a_r1_wgray_step: assert property (@(posedge clk) disable iff (clr)
    $past(!clr) |-> ($countones(wgray ^ $past(wgray)) <= 1));
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
  import dmf_pkg::*;
#(
  parameter int AW = 8,
  localparam int PW = AW + 1
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              fwft,
  input  logic              rd_ready,
  input  logic [PW-1:0]     wgray_s,
  input  logic [AW-1:0]     ae_off,
  input  logic [WORD_W-1:0] mem_q,
  output logic [AW-1:0]     raddr,
  output logic [PW-1:0]     rgray,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              almost_empty
);
  logic [PW-1:0] rbin, rnext, wbin_s, rlevel;
  logic          core_empty, pop, hold_q;

  assign wbin_s     = PW'(from_gray(CONV_W'(wgray_s)));
  assign core_empty = (rbin == wbin_s);
  assign pop        = !core_empty && (fwft ? (!hold_q || rd_ready) : rd_ready);
  assign rnext      = rbin + PW'(1);
  assign raddr      = rbin[AW-1:0];
  assign rd_valid   = fwft ? hold_q : !core_empty;
  assign rlevel     = (wbin_s - rbin) + PW'(fwft && hold_q);
  assign almost_empty = (rlevel <= {1'b0, ae_off});

  always_ff @(posedge clk) begin
    if (clr) begin
      rbin    <= '0;
      rgray   <= '0;
      hold_q  <= 1'b0;
      rd_data <= '0;
    end else begin
      if (pop) begin
        rbin    <= rnext;
        rgray   <= PW'(to_gray(CONV_W'(rnext)));
        rd_data <= mem_q;
      end
      if (fwft) begin
        if (pop)           hold_q <= 1'b1;
        else if (rd_ready) hold_q <= 1'b0;
      end else begin
        hold_q <= 1'b0;
      end
    end
  end

  // R5: nothing moves the read pointer while empty
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (clr)
    core_empty |=> $stable(rbin));

  // R3: an unconsumed head word stays presented
  a_r3_head_held: assert property (@(posedge clk) disable iff (clr)
    (fwft && rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R2: in registered timing the output only changes on an accepted read
  a_r2_data_held: assert property (@(posedge clk) disable iff (clr)
    (!fwft && !(rd_ready && rd_valid)) |=> $stable(rd_data));

  // R1: read pointer published one Gray step at a time
  a_r1_rgray_step: assert property (@(posedge clk) disable iff (clr)
    $past(!clr) |-> ($countones(rgray ^ $past(rgray)) <= 1));
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import dmf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              mode_fwft,
  input  logic [1:0]        dflt_sel,
  input  logic              cfg_load,
  input  logic [AW-1:0]     cfg_ae,
  input  logic [AW-1:0]     cfg_af,
  input  logic              ser_en,
  input  logic              ser_bit,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data,
  output logic              almost_empty,
  output logic              almost_full
);
  logic              clr, push, full, fwft;
  logic [AW-1:0]     ae_off, af_off, waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] mem_q;

  assign clr      = !mrst_n || !prst_n;
  assign wr_ready = !full;
  assign mem_q    = mem[raddr];

  always_ff @(posedge wr_clk) begin
    if (push) mem[waddr] <= wr_data;
  end

  fifo_cfg #(.AW(AW)) u_cfg (
    .clk(wr_clk), .mrst_n(mrst_n), .mode_in(mode_fwft), .dflt_sel(dflt_sel),
    .cfg_load(cfg_load), .cfg_ae(cfg_ae), .cfg_af(cfg_af),
    .ser_en(ser_en), .ser_bit(ser_bit),
    .fwft(fwft), .ae_off(ae_off), .af_off(af_off)
  );

  ptr_sync #(.W(PW)) u_w2r (.clk(rd_clk), .clr(clr), .d(wgray), .q(wgray_s));
  ptr_sync #(.W(PW)) u_r2w (.clk(wr_clk), .clr(clr), .d(rgray), .q(rgray_s));

  fifo_wr_ctl #(.AW(AW)) u_wr (
    .clk(wr_clk), .clr(clr), .wr_valid(wr_valid), .rgray_s(rgray_s),
    .af_off(af_off), .push(push), .waddr(waddr), .wgray(wgray),
    .full(full), .almost_full(almost_full)
  );

  fifo_rd_ctl #(.AW(AW)) u_rd (
    .clk(rd_clk), .clr(clr), .fwft(fwft), .rd_ready(rd_ready),
    .wgray_s(wgray_s), .ae_off(ae_off), .mem_q(mem_q), .raddr(raddr),
    .rgray(rgray), .rd_valid(rd_valid), .rd_data(rd_data),
    .almost_empty(almost_empty)
  );

  initial begin
    a_depth_pow2: assert (DEPTH == (1 << AW) && AW >= 7);
  end
endmodule

// File: tb/dual_mode_fifo_test.sv
module dual_mode_fifo_test;
  localparam int DEPTH = 256;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1, mode_fwft = 1'b0;
  logic [1:0] dflt_sel = 2'b00;
  logic cfg_load = 1'b0, ser_en = 1'b0, ser_bit = 1'b0;
  logic [AW-1:0] cfg_ae = '0, cfg_af = '0;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic [35:0] wr_data = '0;
  logic wr_ready, rd_valid, almost_empty, almost_full;
  logic [35:0] rd_data;
  int errs = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_mode_fifo #(.DEPTH(DEPTH)) uut (
    .wr_clk(clk), .rd_clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .mode_fwft(mode_fwft), .dflt_sel(dflt_sel), .cfg_load(cfg_load),
    .cfg_ae(cfg_ae), .cfg_af(cfg_af), .ser_en(ser_en), .ser_bit(ser_bit),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  function automatic logic [35:0] wd(input int i);
    return {4'(i * 5 + 3), 32'(i) ^ 32'hC0DE_5A00};
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_n(input int first, input int n);
    for (int k = 0; k < n; k++) begin
      wr_valid = 1'b1;
      wr_data  = wd(first + k);
      @(negedge clk);
    end
    wr_valid = 1'b0;
  endtask

  task automatic rd_std(input int idx, input string req);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    chk(req, rd_data, wd(idx));
  endtask

  task automatic rd_fw(input int idx, input string req);
    chk(req, {35'd0, rd_valid}, 36'd1);
    chk(req, rd_data, wd(idx));
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic master_reset(input logic m, input logic [1:0] s);
    @(negedge clk);
    mrst_n = 1'b0; mode_fwft = m; dflt_sel = s;
    idle(3);
    mrst_n = 1'b1;
    idle(3);
  endtask

  task automatic t_reset_state;
    master_reset(1'b0, 2'b00);
    chk("R11 empty after reset", {35'd0, rd_valid}, 36'd0);
    chk("R11 ready after reset", {35'd0, wr_ready}, 36'd1);
    chk("R6 ae after reset", {35'd0, almost_empty}, 36'd1);
    chk("R7 af after reset", {35'd0, almost_full}, 36'd0);
  endtask

  task automatic t_std_order;
    master_reset(1'b0, 2'b00);
    wr_n(10, 5);
    idle(4);
    chk("R2 not empty", {35'd0, rd_valid}, 36'd1);
    for (int i = 0; i < 5; i++) rd_std(10 + i, "R1 R2 order");
    idle(2);
    chk("R2 data held without read", rd_data, wd(14));
    chk("R2 empty after drain", {35'd0, rd_valid}, 36'd0);
  endtask

  task automatic t_fwft;
    master_reset(1'b1, 2'b00);
    wr_n(40, 1);
    idle(5);
    chk("R3 head without strobe", rd_data, wd(40));
    chk("R3 valid without strobe", {35'd0, rd_valid}, 36'd1);
    wr_n(41, 3);
    idle(5);
    chk("R3 head held", rd_data, wd(40));
    for (int i = 0; i < 4; i++) rd_fw(40 + i, "R3 R1 fall-through order");
    idle(2);
    chk("R3 empty after drain", {35'd0, rd_valid}, 36'd0);
  endtask

  task automatic t_full_empty;
    master_reset(1'b0, 2'b00);
    wr_n(100, DEPTH - 1);
    chk("R4 ready one below full", {35'd0, wr_ready}, 36'd1);
    wr_n(100 + DEPTH - 1, 1);
    chk("R4 not ready when full", {35'd0, wr_ready}, 36'd0);
    wr_n(9999, 2);
    idle(4);
    for (int i = 0; i < DEPTH; i++) rd_std(100 + i, "R4 R1 full drain");
    idle(2);
    chk("R4 extra write dropped", {35'd0, rd_valid}, 36'd0);
    rd_ready = 1'b1;
    idle(3);
    rd_ready = 1'b0;
    chk("R5 data unchanged on empty read", rd_data, wd(100 + DEPTH - 1));
    wr_n(777, 1);
    idle(4);
    rd_std(777, "R5 pointer not advanced");
  endtask

  task automatic t_defaults;
    master_reset(1'b0, 2'b01);
    wr_n(0, 16);
    idle(4);
    chk("R8 R6 ae at 16", {35'd0, almost_empty}, 36'd1);
    wr_n(16, 1);
    idle(4);
    chk("R8 R6 ae above 16", {35'd0, almost_empty}, 36'd0);
    wr_n(17, 239 - 17);
    idle(2);
    chk("R8 R7 af at 239", {35'd0, almost_full}, 36'd0);
    wr_n(239, 1);
    chk("R8 R7 af at 240", {35'd0, almost_full}, 36'd1);
    master_reset(1'b0, 2'b10);
    wr_n(0, 64);
    idle(4);
    chk("R8 ae at 64", {35'd0, almost_empty}, 36'd1);
    wr_n(64, 1);
    idle(4);
    chk("R8 ae above 64", {35'd0, almost_empty}, 36'd0);
  endtask

  task automatic t_parallel;
    master_reset(1'b0, 2'b00);
    cfg_ae = 8'd3; cfg_af = 8'd5; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    wr_n(0, 3);
    idle(4);
    chk("R9 ae at 3", {35'd0, almost_empty}, 36'd1);
    wr_n(3, 1);
    idle(4);
    chk("R9 ae at 4", {35'd0, almost_empty}, 36'd0);
    wr_n(4, 250 - 4);
    chk("R9 af at 250", {35'd0, almost_full}, 36'd0);
    wr_n(250, 1);
    chk("R9 af at 251", {35'd0, almost_full}, 36'd1);
  endtask

  task automatic t_serial;
    logic [15:0] v;
    master_reset(1'b0, 2'b00);
    v = {8'd10, 8'd2};
    ser_en = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      ser_bit = v[i];
      @(negedge clk);
    end
    ser_en = 1'b0;
    wr_n(0, 10);
    idle(4);
    chk("R10 ae at 10", {35'd0, almost_empty}, 36'd1);
    wr_n(10, 1);
    idle(4);
    chk("R10 ae at 11", {35'd0, almost_empty}, 36'd0);
    wr_n(11, 253 - 11);
    chk("R10 af at 253", {35'd0, almost_full}, 36'd0);
    wr_n(253, 1);
    chk("R10 af at 254", {35'd0, almost_full}, 36'd1);
  endtask

  task automatic t_partial;
    master_reset(1'b1, 2'b00);
    cfg_ae = 8'd4; cfg_af = 8'd8; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    wr_n(500, 3);
    idle(5);
    prst_n = 1'b0;
    idle(3);
    prst_n = 1'b1;
    idle(3);
    chk("R12 emptied", {35'd0, rd_valid}, 36'd0);
    wr_n(600, 5);
    idle(6);
    chk("R12 mode kept", rd_data, wd(600));
    chk("R12 offset kept", {35'd0, almost_empty}, 36'd0);
    master_reset(1'b0, 2'b00);
    wr_n(700, 5);
    idle(4);
    chk("R11 defaults restored", {35'd0, almost_empty}, 36'd1);
    chk("R11 registered mode restored", rd_data, 36'd0);
    rd_std(700, "R11 registered read");
  endtask

  task automatic t_simultaneous;
    master_reset(1'b0, 2'b00);
    wr_n(800, 2);
    idle(4);
    wr_valid = 1'b1; wr_data = wd(802); rd_ready = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; rd_ready = 1'b0;
    chk("R13 read on shared edge", rd_data, wd(800));
    idle(4);
    rd_std(801, "R13 second");
    rd_std(802, "R13 write on shared edge");
    idle(1);
    chk("R13 empty after", {35'd0, rd_valid}, 36'd0);
  endtask

  initial begin
    idle(2);
    t_reset_state();
    t_std_order();
    t_fwft();
    t_full_empty();
    t_defaults();
    t_parallel();
    t_serial();
    t_partial();
    t_simultaneous();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule